// File: doc/BRIEF.md
# Uncached AXI Access Formatter

This block takes one memory access request at a time from a load/store or page-walk unit and turns it into a legal AXI4 read or write transaction. A request states the address, the access size, the number of beats, the kind of memory (device, normal non-cacheable, normal write-through, or translation table walk), whether the location is shared, and whether the access is exclusive. The block checks the shape against a small fixed set of allowed transaction shapes. It then drives the address channel, streams the write beats with byte strobes placed on the correct lanes, collects read beats, and reports completion with a merged response code.

Requests that would give an illegal shape are refused with a one-cycle reject pulse and cause no bus activity. Only one transaction is in flight at a time. The requester sees `req_ready` high only while the block is idle.

Top module: `uc_axi_fmt`

## Requirements
- R1: A request is rejected (`rej` high for exactly one cycle, no AW, AR or W valid) when its beat count `req_len` is not 1, 2 or 4, when `req_size` exceeds 4, when a multi-beat request has `req_size` other than 4 (128-bit), or when an exclusive request has more than one beat.
- R2: A request is rejected when the address is not a multiple of the access byte width (`1 << req_size`), or when a multi-beat burst would pass the end of its 64-byte line, i.e. `addr[5:4] + req_len > 4`. A burst that ends on or before the line end is accepted.
- R3: An accepted request drives AxADDR = request address, AxBURST = 2'b01 (INCR), AxLEN = beat count minus one and AxSIZE = `req_size` (log2 of the byte width), held stable until the address handshake.
- R4: A non-exclusive single-beat read to normal memory (`req_kind` 1 = non-cacheable or 2 = write-through) with `req_size` 0 or 1 is rejected. Device reads (`req_kind` 0) of any size from 0 to 4 are accepted.
- R5: A translation table walk request (`req_kind` 3) is accepted only as a non-exclusive single-beat read with `req_size` 2 or 3. Any other walk request is rejected.
- R6: AxLOCK is 1 exactly when the access is exclusive and either the memory is device or the normal memory is shared (`req_shared`=1). An exclusive access to non-shared normal memory is issued with AxLOCK 0.
- R7: For a single-beat write smaller than 128 bits, WSTRB is the low `1 << req_size` bits of `wd_be` shifted left by `addr[3:0]`, and WDATA is `wd_data` shifted left by 8*`addr[3:0]` bits. For a 128-bit beat, WSTRB equals `wd_be` unchanged. All-zero strobes are issued as given.
- R8: A write produces exactly `req_len` W beats, one per accepted `wd` beat, with WLAST high only on the final beat. WVALID, WDATA, WSTRB and WLAST hold while WREADY is low.
- R9: Each R handshake is presented on `rd_valid`/`rd_data` one cycle later, with the raw beat data.
- R10: `cpl` pulses for one cycle after the B handshake of a write or the last R beat of a read. `cpl_resp` is the first SLVERR/DECERR code (2 or 3) seen in the transaction, or otherwise the response of the final handshake (0 OKAY, 1 EXOKAY).
- R11: `req_ready` is high only while idle. After a legal request is taken it stays low until the cycle of its `cpl` pulse. After a rejected request it stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_kind | input | 2 | 0 device, 1 normal non-cacheable, 2 normal write-through, 3 table walk |
| req_shared | input | 1 | Location is shared |
| req_excl | input | 1 | Exclusive access |
| req_size | input | 3 | log2 of bytes per beat |
| req_len | input | 3 | Beat count |
| wd_valid | input | 1 | Write beat present |
| wd_ready | output | 1 | Write beat taken |
| wd_data | input | DATA_W | Write data, low-aligned for narrow beats |
| wd_be | input | DATA_W/8 | Byte enables, low-aligned for narrow beats |
| rd_valid | output | 1 | Read beat out |
| rd_data | output | DATA_W | Read beat data |
| rej | output | 1 | Request refused |
| cpl | output | 1 | Transaction finished |
| cpl_resp | output | 2 | Merged response |
| awvalid | output | 1 | AXI AW valid |
| awready | input | 1 | AXI AW ready |
| awaddr | output | ADDR_W | AXI AW address |
| awlen | output | 8 | AXI AW length |
| awsize | output | 3 | AXI AW size |
| awburst | output | 2 | AXI AW burst |
| awlock | output | 1 | AXI AW lock |
| wvalid | output | 1 | AXI W valid |
| wready | input | 1 | AXI W ready |
| wdata | output | DATA_W | AXI W data |
| wstrb | output | DATA_W/8 | AXI W strobes |
| wlast | output | 1 | AXI W last |
| bvalid | input | 1 | AXI B valid |
| bready | output | 1 | AXI B ready |
| bresp | input | 2 | AXI B response |
| arvalid | output | 1 | AXI AR valid |
| arready | input | 1 | AXI AR ready |
| araddr | output | ADDR_W | AXI AR address |
| arlen | output | 8 | AXI AR length |
| arsize | output | 3 | AXI AR size |
| arburst | output | 2 | AXI AR burst |
| arlock | output | 1 | AXI AR lock |
| rvalid | input | 1 | AXI R valid |
| rready | output | 1 | AXI R ready |
| rdata | input | DATA_W | AXI R data |
| rresp | input | 2 | AXI R response |
| rlast | input | 1 | AXI R last |

## Verification
The bench builds the block with its default parameters: a 32-bit address, 128-bit data and a 64-byte line, so a line holds exactly four beats. With these values every beat position inside a line can be reached. A four-beat burst is legal only from the line start, and two-beat bursts from each of the three upper positions either fit or cross the boundary. The 16 byte lanes let narrow writes be placed at odd offsets such as lane 5 and checked against a shifted strobe mask.

// File: rtl/uc_axi_pkg.sv
package uc_axi_pkg;

  typedef enum logic [1:0] {
    MK_DEV  = 2'd0,
    MK_NC   = 2'd1,
    MK_WT   = 2'd2,
    MK_WALK = 2'd3
  } mem_kind_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_WR,
    S_WB,
    S_RA,
    S_RD
  } seq_state_e;

  localparam logic [1:0] BURST_INCR = 2'b01;
  localparam logic [1:0] RESP_OKAY  = 2'b00;

endpackage

// File: rtl/uc_axi_shape.sv
module uc_axi_shape
  import uc_axi_pkg::*;
#(
  parameter int DATA_W     = 128,
  parameter int LINE_BYTES = 64
) (
  input  logic                      write,
  input  logic [$clog2(LINE_BYTES)-1:0] addr_lo,
  input  logic [1:0]                kind,
  input  logic                      shared,
  input  logic                      excl,
  input  logic [2:0]                size,
  input  logic [2:0]                len,
  output logic                      legal,
  output logic                      lock,
  output logic [7:0]                axlen
);
  localparam int STRB_W    = DATA_W / 8;
  localparam int OFF_W     = $clog2(STRB_W);
  localparam int FULL_SIZE = OFF_W;
  localparam int LINE_W    = $clog2(LINE_BYTES);
  localparam int BPL       = LINE_BYTES / STRB_W;

  logic len_ok, size_ok, align_ok, multi, multi_ok, kind_ok, excl_ok;
  int   beat_end;

  always_comb begin
    len_ok  = (len == 3'd1) || (len == 3'd2) || (len == 3'd4);
    size_ok = (int'(size) <= FULL_SIZE);
    multi   = (len != 3'd1);

    align_ok = 1'b1;
    for (int i = 0; i < OFF_W; i++) begin
      if ((i < int'(size)) && addr_lo[i]) align_ok = 1'b0;
    end

    beat_end = int'(addr_lo[LINE_W-1:OFF_W]) + int'(len);
    multi_ok = !multi || ((int'(size) == FULL_SIZE) && (beat_end <= BPL));
    excl_ok  = !(excl && multi);

    kind_ok = 1'b1;
    if (kind == MK_WALK) begin
      kind_ok = !write && !excl && !multi && ((size == 3'd2) || (size == 3'd3));
    end else if ((kind == MK_NC) || (kind == MK_WT)) begin
      if (!write && !excl && !multi && (size < 3'd2)) kind_ok = 1'b0;
    end

    legal = len_ok && size_ok && align_ok && multi_ok && excl_ok && kind_ok;
    lock  = excl && (kind != MK_WALK) && ((kind == MK_DEV) || shared);
    axlen = {5'b0, len - 3'd1};
  end

endmodule

// File: rtl/uc_axi_lane.sv
module uc_axi_lane #(
  parameter int DATA_W = 128
) (
  input  logic                          multi,
  input  logic [2:0]                    size,
  input  logic [$clog2(DATA_W/8)-1:0]   off,
  input  logic [DATA_W/8-1:0]           be_in,
  input  logic [DATA_W-1:0]             data_in,
  output logic [DATA_W/8-1:0]           strb_out,
  output logic [DATA_W-1:0]             data_out
);
  localparam int STRB_W = DATA_W / 8;

  logic [STRB_W-1:0] width_mask;

  always_comb begin
    for (int i = 0; i < STRB_W; i++) begin
      width_mask[i] = (i < (1 << size));
    end
    if (multi) begin
      strb_out = be_in;
      data_out = data_in;
    end else begin
      strb_out = (be_in & width_mask) << off;
      data_out = data_in << {off, 3'b000};
    end
  end

endmodule

// File: rtl/uc_axi_seq.sv
module uc_axi_seq
  import uc_axi_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 128
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        req_valid,
  output logic                        req_ready,
  input  logic                        req_write,
  input  logic [ADDR_W-1:0]           req_addr,
  input  logic [2:0]                  req_size,
  input  logic [2:0]                  req_len,
  input  logic                        legal,
  input  logic                        lock,
  input  logic [7:0]                  axlen,
  output logic [2:0]                  cur_size,
  output logic [$clog2(DATA_W/8)-1:0] cur_off,
  output logic                        cur_multi,
  input  logic                        wd_valid,
  output logic                        wd_ready,
  input  logic [DATA_W/8-1:0]         lane_strb,
  input  logic [DATA_W-1:0]           lane_data,
  output logic                        rd_valid,
  output logic [DATA_W-1:0]           rd_data,
  output logic                        rej,
  output logic                        cpl,
  output logic [1:0]                  cpl_resp,
  output logic                        awvalid,
  input  logic                        awready,
  output logic [ADDR_W-1:0]           awaddr,
  output logic [7:0]                  awlen,
  output logic [2:0]                  awsize,
  output logic [1:0]                  awburst,
  output logic                        awlock,
  output logic                        wvalid,
  input  logic                        wready,
  output logic [DATA_W-1:0]           wdata,
  output logic [DATA_W/8-1:0]         wstrb,
  output logic                        wlast,
  input  logic                        bvalid,
  output logic                        bready,
  input  logic [1:0]                  bresp,
  output logic                        arvalid,
  input  logic                        arready,
  output logic [ADDR_W-1:0]           araddr,
  output logic [7:0]                  arlen,
  output logic [2:0]                  arsize,
  output logic [1:0]                  arburst,
  output logic                        arlock,
  input  logic                        rvalid,
  output logic                        rready,
  input  logic [DATA_W-1:0]           rdata,
  input  logic [1:0]                  rresp,
  input  logic                        rlast
);
  localparam int STRB_W = DATA_W / 8;
  localparam int OFF_W  = $clog2(STRB_W);

  seq_state_e  state;
  logic [2:0]  beats_left;
  logic        aw_done, w_done, has_err;
  logic [1:0]  err_code;
  logic        aw_fire, w_fire, wd_fire;

  assign req_ready = (state == S_IDLE);
  assign bready    = (state == S_WB);
  assign rready    = (state == S_RD);
  assign wd_ready  = (state == S_WR) && (beats_left != 3'd0) && (!wvalid || wready);
  assign wd_fire   = wd_valid && wd_ready;
  assign aw_fire   = awvalid && awready;
  assign w_fire    = wvalid && wready;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      beats_left <= '0;
      aw_done    <= 1'b0;
      w_done     <= 1'b0;
      has_err    <= 1'b0;
      err_code   <= RESP_OKAY;
      cur_size   <= '0;
      cur_off    <= '0;
      cur_multi  <= 1'b0;
      rd_valid   <= 1'b0;
      rd_data    <= '0;
      rej        <= 1'b0;
      cpl        <= 1'b0;
      cpl_resp   <= RESP_OKAY;
      awvalid    <= 1'b0;
      awaddr     <= '0;
      awlen      <= '0;
      awsize     <= '0;
      awburst    <= '0;
      awlock     <= 1'b0;
      wvalid     <= 1'b0;
      wdata      <= '0;
      wstrb      <= '0;
      wlast      <= 1'b0;
      arvalid    <= 1'b0;
      araddr     <= '0;
      arlen      <= '0;
      arsize     <= '0;
      arburst    <= '0;
      arlock     <= 1'b0;
    end else begin
      rej      <= 1'b0;
      cpl      <= 1'b0;
      rd_valid <= 1'b0;
      unique case (state)
        S_IDLE: begin
          if (req_valid) begin
            if (!legal) begin
              rej <= 1'b1;
            end else begin
              cur_size  <= req_size;
              cur_off   <= req_addr[OFF_W-1:0];
              cur_multi <= (req_len != 3'd1);
              has_err   <= 1'b0;
              err_code  <= RESP_OKAY;
              if (req_write) begin
                awvalid    <= 1'b1;
                awaddr     <= req_addr;
                awlen      <= axlen;
                awsize     <= req_size;
                awburst    <= BURST_INCR;
                awlock     <= lock;
                beats_left <= req_len;
                aw_done    <= 1'b0;
                w_done     <= 1'b0;
                state      <= S_WR;
              end else begin
                arvalid <= 1'b1;
                araddr  <= req_addr;
                arlen   <= axlen;
                arsize  <= req_size;
                arburst <= BURST_INCR;
                arlock  <= lock;
                state   <= S_RA;
              end
            end
          end
        end
        S_WR: begin
          if (aw_fire) begin
            awvalid <= 1'b0;
            aw_done <= 1'b1;
          end
          if (wd_fire) begin
            wvalid     <= 1'b1;
            wdata      <= lane_data;
            wstrb      <= lane_strb;
            wlast      <= (beats_left == 3'd1);
            beats_left <= beats_left - 3'd1;
          end else if (w_fire) begin
            wvalid <= 1'b0;
            wlast  <= 1'b0;
          end
          if (w_fire && wlast) w_done <= 1'b1;
          if ((aw_done || aw_fire) && (w_done || (w_fire && wlast))) begin
            state <= S_WB;
          end
        end
        S_WB: begin
          if (bvalid) begin
            cpl      <= 1'b1;
            cpl_resp <= bresp;
            state    <= S_IDLE;
          end
        end
        S_RA: begin
          if (arready) begin
            arvalid <= 1'b0;
            state   <= S_RD;
          end
        end
        S_RD: begin
          if (rvalid) begin
            rd_valid <= 1'b1;
            rd_data  <= rdata;
            if (rresp[1] && !has_err) begin
              has_err  <= 1'b1;
              err_code <= rresp;
            end
            if (rlast) begin
              cpl      <= 1'b1;
              cpl_resp <= has_err ? err_code : rresp;
              state    <= S_IDLE;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/uc_axi_fmt.sv
module uc_axi_fmt
  import uc_axi_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 128,
  parameter int LINE_BYTES = 64
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_write,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [1:0]           req_kind,
  input  logic                 req_shared,
  input  logic                 req_excl,
  input  logic [2:0]           req_size,
  input  logic [2:0]           req_len,
  input  logic                 wd_valid,
  output logic                 wd_ready,
  input  logic [DATA_W-1:0]    wd_data,
  input  logic [DATA_W/8-1:0]  wd_be,
  output logic                 rd_valid,
  output logic [DATA_W-1:0]    rd_data,
  output logic                 rej,
  output logic                 cpl,
  output logic [1:0]           cpl_resp,
  output logic                 awvalid,
  input  logic                 awready,
  output logic [ADDR_W-1:0]    awaddr,
  output logic [7:0]           awlen,
  output logic [2:0]           awsize,
  output logic [1:0]           awburst,
  output logic                 awlock,
  output logic                 wvalid,
  input  logic                 wready,
  output logic [DATA_W-1:0]    wdata,
  output logic [DATA_W/8-1:0]  wstrb,
  output logic                 wlast,
  input  logic                 bvalid,
  output logic                 bready,
  input  logic [1:0]           bresp,
  output logic                 arvalid,
  input  logic                 arready,
  output logic [ADDR_W-1:0]    araddr,
  output logic [7:0]           arlen,
  output logic [2:0]           arsize,
  output logic [1:0]           arburst,
  output logic                 arlock,
  input  logic                 rvalid,
  output logic                 rready,
  input  logic [DATA_W-1:0]    rdata,
  input  logic [1:0]           rresp,
  input  logic                 rlast
);
  localparam int STRB_W = DATA_W / 8;
  localparam int OFF_W  = $clog2(STRB_W);
  localparam int LINE_W = $clog2(LINE_BYTES);

  logic              shp_legal, shp_lock;
  logic [7:0]        shp_len;
  logic [2:0]        cur_size;
  logic [OFF_W-1:0]  cur_off;
  logic              cur_multi;
  logic [STRB_W-1:0] lane_strb;
  logic [DATA_W-1:0] lane_data;

  uc_axi_shape #(.DATA_W(DATA_W), .LINE_BYTES(LINE_BYTES)) shape_i (
    .write   (req_write),
    .addr_lo (req_addr[LINE_W-1:0]),
    .kind    (req_kind),
    .shared  (req_shared),
    .excl    (req_excl),
    .size    (req_size),
    .len     (req_len),
    .legal   (shp_legal),
    .lock    (shp_lock),
    .axlen   (shp_len)
  );

  uc_axi_lane #(.DATA_W(DATA_W)) lane_i (
    .multi    (cur_multi),
    .size     (cur_size),
    .off      (cur_off),
    .be_in    (wd_be),
    .data_in  (wd_data),
    .strb_out (lane_strb),
    .data_out (lane_data)
  );

  uc_axi_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) seq_i (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_size  (req_size),
    .req_len   (req_len),
    .legal     (shp_legal),
    .lock      (shp_lock),
    .axlen     (shp_len),
    .cur_size  (cur_size),
    .cur_off   (cur_off),
    .cur_multi (cur_multi),
    .wd_valid  (wd_valid),
    .wd_ready  (wd_ready),
    .lane_strb (lane_strb),
    .lane_data (lane_data),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data),
    .rej       (rej),
    .cpl       (cpl),
    .cpl_resp  (cpl_resp),
    .awvalid   (awvalid),
    .awready   (awready),
    .awaddr    (awaddr),
    .awlen     (awlen),
    .awsize    (awsize),
    .awburst   (awburst),
    .awlock    (awlock),
    .wvalid    (wvalid),
    .wready    (wready),
    .wdata     (wdata),
    .wstrb     (wstrb),
    .wlast     (wlast),
    .bvalid    (bvalid),
    .bready    (bready),
    .bresp     (bresp),
    .arvalid   (arvalid),
    .arready   (arready),
    .araddr    (araddr),
    .arlen     (arlen),
    .arsize    (arsize),
    .arburst   (arburst),
    .arlock    (arlock),
    .rvalid    (rvalid),
    .rready    (rready),
    .rdata     (rdata),
    .rresp     (rresp),
    .rlast     (rlast)
  );

endmodule

// File: rtl/uc_axi_fmt_chk.sv
module uc_axi_fmt_chk #(
  parameter int DATA_W     = 128,
  parameter int LINE_BYTES = 64
) (
  input logic                              clk,
  input logic                              rst,
  input logic                              req_valid,
  input logic                              req_ready,
  input logic                              rej,
  input logic                              cpl,
  input logic                              awvalid,
  input logic                              awready,
  input logic [$clog2(LINE_BYTES)-1:0]     aw_lo,
  input logic [7:0]                        awlen,
  input logic [2:0]                        awsize,
  input logic                              wvalid,
  input logic                              wready,
  input logic [DATA_W-1:0]                 wdata,
  input logic [DATA_W/8-1:0]               wstrb,
  input logic                              wlast,
  input logic                              arvalid,
  input logic [$clog2(LINE_BYTES)-1:0]     ar_lo,
  input logic [7:0]                        arlen,
  input logic [2:0]                        arsize
);
  localparam int STRB_W    = DATA_W / 8;
  localparam int OFF_W     = $clog2(STRB_W);
  localparam int LINE_W    = $clog2(LINE_BYTES);
  localparam int BPL       = LINE_BYTES / STRB_W;
  localparam logic [2:0] FULL = 3'(OFF_W);

  a_r1_aw_multi_full: assert property (@(posedge clk) disable iff (rst)
    (awvalid && awlen != 8'd0) |-> (awsize == FULL));

  a_r1_ar_multi_full: assert property (@(posedge clk) disable iff (rst)
    (arvalid && arlen != 8'd0) |-> (arsize == FULL));

  a_r1_rej_quiet: assert property (@(posedge clk) disable iff (rst)
    rej |-> (!awvalid && !arvalid && !wvalid));

  a_r2_aw_in_line: assert property (@(posedge clk) disable iff (rst)
    awvalid |-> ((int'(aw_lo[LINE_W-1:OFF_W]) + int'(awlen)) < BPL));

  a_r2_ar_in_line: assert property (@(posedge clk) disable iff (rst)
    arvalid |-> ((int'(ar_lo[LINE_W-1:OFF_W]) + int'(arlen)) < BPL));

  a_r3_aw_hold: assert property (@(posedge clk) disable iff (rst)
    (awvalid && !awready) |=> (awvalid && $stable(aw_lo) && $stable(awlen) && $stable(awsize)));

  a_r8_w_hold: assert property (@(posedge clk) disable iff (rst)
    (wvalid && !wready) |=> (wvalid && $stable(wdata) && $stable(wstrb) && $stable(wlast)));

  a_r10_cpl_pulse: assert property (@(posedge clk) disable iff (rst)
    cpl |=> !cpl);

  a_r11_take_one: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> (rej == req_ready));

endmodule

bind uc_axi_fmt uc_axi_fmt_chk #(.DATA_W(DATA_W), .LINE_BYTES(LINE_BYTES)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .rej       (rej),
  .cpl       (cpl),
  .awvalid   (awvalid),
  .awready   (awready),
  .aw_lo     (awaddr[LINE_W-1:0]),
  .awlen     (awlen),
  .awsize    (awsize),
  .wvalid    (wvalid),
  .wready    (wready),
  .wdata     (wdata),
  .wstrb     (wstrb),
  .wlast     (wlast),
  .arvalid   (arvalid),
  .ar_lo     (araddr[LINE_W-1:0]),
  .arlen     (arlen),
  .arsize    (arsize)
);

// File: tb/uc_axi_fmt_tb_top.sv
`timescale 1ns/1ps
module uc_axi_fmt_tb_top;
  import uc_axi_pkg::*;

  localparam int AW = 32;
  localparam int DW = 128;
  localparam int SW = DW / 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic          req_valid = 0, req_write = 0, req_shared = 0, req_excl = 0;
  logic [AW-1:0] req_addr = '0;
  logic [1:0]    req_kind = '0;
  logic [2:0]    req_size = '0, req_len = '0;
  logic          wd_valid = 0;
  logic [DW-1:0] wd_data = '0;
  logic [SW-1:0] wd_be = '0;
  logic          awready = 0, wready = 0, bvalid = 0, arready = 0, rvalid = 0, rlast = 0;
  logic [1:0]    bresp = '0, rresp = '0;
  logic [DW-1:0] rdata = '0;

  logic          req_ready, wd_ready, rd_valid, rej, cpl;
  logic [DW-1:0] rd_data, wdata;
  logic [1:0]    cpl_resp, awburst, arburst;
  logic          awvalid, awlock, wvalid, wlast, bready, arvalid, arlock, rready;
  logic [AW-1:0] awaddr, araddr;
  logic [7:0]    awlen, arlen;
  logic [2:0]    awsize, arsize;
  logic [SW-1:0] wstrb;

  uc_axi_fmt #(.ADDR_W(AW), .DATA_W(DW), .LINE_BYTES(64)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_kind(req_kind),
    .req_shared(req_shared), .req_excl(req_excl), .req_size(req_size),
    .req_len(req_len), .wd_valid(wd_valid), .wd_ready(wd_ready),
    .wd_data(wd_data), .wd_be(wd_be), .rd_valid(rd_valid), .rd_data(rd_data),
    .rej(rej), .cpl(cpl), .cpl_resp(cpl_resp),
    .awvalid(awvalid), .awready(awready), .awaddr(awaddr), .awlen(awlen),
    .awsize(awsize), .awburst(awburst), .awlock(awlock),
    .wvalid(wvalid), .wready(wready), .wdata(wdata), .wstrb(wstrb), .wlast(wlast),
    .bvalid(bvalid), .bready(bready), .bresp(bresp),
    .arvalid(arvalid), .arready(arready), .araddr(araddr), .arlen(arlen),
    .arsize(arsize), .arburst(arburst), .arlock(arlock),
    .rvalid(rvalid), .rready(rready), .rdata(rdata), .rresp(rresp), .rlast(rlast)
  );

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  logic [DW-1:0] wd_d [4];
  logic [SW-1:0] wd_b [4];
  logic [DW-1:0] ex_d [4];
  logic [SW-1:0] ex_s [4];

  task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send(input bit wr, input logic [AW-1:0] a, input logic [1:0] k,
                      input bit sh, input bit ex, input logic [2:0] sz, input logic [2:0] ln);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_kind = k;
    req_shared = sh; req_excl = ex; req_size = sz; req_len = ln;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic expect_rej(input string tag);
    chk(rej == 1'b1, tag, DW'(rej), 1);
    chk(!awvalid && !arvalid && !wvalid, tag, DW'({awvalid, arvalid, wvalid}), 0);
    chk(req_ready == 1'b1, {tag, " ready"}, DW'(req_ready), 1);
    @(negedge clk);
    chk(rej == 1'b0, {tag, " pulse"}, DW'(rej), 0);
  endtask

  task automatic serve_read(input int n, input int eb, input logic [1:0] ecode,
                            input logic [1:0] okc, input logic [1:0] exp_resp, input string tag);
    arready = 1;
    @(negedge clk);
    arready = 0;
    chk(!arvalid && rready, {tag, " R9 ar done"}, DW'({arvalid, rready}), 1);
    for (int i = 0; i < n; i++) begin
      rvalid = 1; rdata = {4{32'hC0DE0000 + 32'(i)}};
      rresp = (i == eb) ? ecode : okc; rlast = (i == n - 1);
      @(negedge clk);
      chk(rd_valid && rd_data == {4{32'hC0DE0000 + 32'(i)}}, {tag, " R9 beat"},
          rd_data, {4{32'hC0DE0000 + 32'(i)}});
      chk(cpl == (i == n - 1), {tag, " R10 cpl"}, DW'(cpl), DW'(i == n - 1));
    end
    rvalid = 0; rlast = 0;
    chk(cpl_resp == exp_resp, {tag, " R10 resp"}, DW'(cpl_resp), DW'(exp_resp));
    @(negedge clk);
    chk(!cpl && req_ready, {tag, " R11 idle"}, DW'({cpl, req_ready}), 1);
  endtask

  task automatic serve_write(input int n, input logic [1:0] br, input string tag);
    awready = 1;
    @(negedge clk);
    awready = 0;
    chk(!awvalid, {tag, " R3 aw done"}, DW'(awvalid), 0);
    wready = 1;
    for (int i = 0; i < n; i++) begin
      wd_valid = 1; wd_data = wd_d[i]; wd_be = wd_b[i];
      @(negedge clk);
      chk(wvalid && wstrb == ex_s[i], {tag, " R7 strb"}, DW'(wstrb), DW'(ex_s[i]));
      chk(wdata == ex_d[i], {tag, " R7 data"}, wdata, ex_d[i]);
      chk(wlast == (i == n - 1), {tag, " R8 last"}, DW'(wlast), DW'(i == n - 1));
    end
    wd_valid = 0;
    @(negedge clk);
    wready = 0;
    chk(!wvalid && bready, {tag, " R8 w end"}, DW'({wvalid, bready}), 1);
    chk(!req_ready, {tag, " R11 busy"}, DW'(req_ready), 0);
    bvalid = 1; bresp = br;
    @(negedge clk);
    bvalid = 0;
    chk(cpl && cpl_resp == br, {tag, " R10 b"}, DW'({cpl, cpl_resp}), DW'({1'b1, br}));
    chk(req_ready, {tag, " R11 back"}, DW'(req_ready), 1);
    @(negedge clk);
    chk(!cpl, {tag, " R10 pulse"}, DW'(cpl), 0);
  endtask

  task automatic t_reset();
    chk(req_ready && !awvalid && !arvalid && !wvalid && !rej && !cpl, "R11 reset",
        DW'({req_ready, awvalid, arvalid, wvalid, rej, cpl}), DW'(6'b100000));
  endtask

  task automatic t_reject_shapes();
    send(0, 32'h1000, MK_DEV, 0, 0, 3'd4, 3'd3); expect_rej("R1 len3");
    send(1, 32'h1000, MK_DEV, 0, 0, 3'd4, 3'd0); expect_rej("R1 len0");
    send(0, 32'h1000, MK_NC, 0, 0, 3'd3, 3'd2);  expect_rej("R1 narrow burst");
    send(1, 32'h1000, MK_DEV, 0, 0, 3'd5, 3'd1); expect_rej("R1 size5");
    send(0, 32'h1000, MK_DEV, 0, 1, 3'd4, 3'd2); expect_rej("R1 excl burst");
  endtask

  task automatic t_line_cross();
    send(0, 32'h30, MK_NC, 0, 0, 3'd4, 3'd2);  expect_rej("R2 cross len2");
    send(0, 32'h10, MK_NC, 0, 0, 3'd4, 3'd4);  expect_rej("R2 cross len4");
    send(1, 32'h102, MK_DEV, 0, 0, 3'd2, 3'd1); expect_rej("R2 misalign w");
    send(0, 32'h104, MK_DEV, 0, 0, 3'd3, 3'd1); expect_rej("R2 misalign d");
    send(0, 32'h20, MK_NC, 0, 0, 3'd4, 3'd2);
    chk(arvalid && araddr == 32'h20 && arlen == 8'd1, "R2 fits line", DW'(araddr), 32'h20);
    serve_read(2, -1, 2'd0, 2'd0, 2'd0, "R2 rd");
  endtask

  task automatic t_read_burst();
    send(0, 32'h1000, MK_DEV, 0, 0, 3'd4, 3'd4);
    chk(arvalid && araddr == 32'h1000, "R3 araddr", DW'(araddr), 32'h1000);
    chk(arlen == 8'd3 && arsize == 3'd4 && arburst == 2'b01 && !arlock, "R3 ar fields",
        DW'({arlen, arsize, arburst, arlock}), DW'({8'd3, 3'd4, 2'b01, 1'b0}));
    chk(!req_ready, "R11 busy rd", DW'(req_ready), 0);
    serve_read(4, -1, 2'd0, 2'd0, 2'd0, "R9 burst4");
    send(0, 32'h2010, MK_WT, 0, 0, 3'd4, 3'd2);
    serve_read(2, 0, 2'd3, 2'd0, 2'd3, "R10 sticky err");
  endtask

  task automatic t_narrow_read();
    send(0, 32'h200, MK_NC, 0, 0, 3'd0, 3'd1); expect_rej("R4 nc byte");
    send(0, 32'h202, MK_WT, 1, 0, 3'd1, 3'd1); expect_rej("R4 wt half");
    send(0, 32'h207, MK_DEV, 0, 0, 3'd0, 3'd1);
    chk(arvalid && arsize == 3'd0 && arlen == 8'd0, "R4 dev byte", DW'(arsize), 0);
    serve_read(1, -1, 2'd0, 2'd0, 2'd0, "R4 dev rd");
    send(0, 32'h209, MK_NC, 0, 1, 3'd0, 3'd1);
    chk(arvalid && arsize == 3'd0 && !arlock, "R6 excl nonshared", DW'({arvalid, arlock}), DW'(2'b10));
    serve_read(1, -1, 2'd0, 2'd0, 2'd0, "R6 rd");
  endtask

  task automatic t_walk();
    send(0, 32'h8, MK_WALK, 0, 0, 3'd3, 3'd1);
    chk(arvalid && arsize == 3'd3 && arlen == 8'd0, "R5 walk ok", DW'(arsize), 3);
    serve_read(1, -1, 2'd0, 2'd0, 2'd0, "R5 rd");
    send(1, 32'h8, MK_WALK, 0, 0, 3'd3, 3'd1); expect_rej("R5 walk write");
    send(0, 32'h0, MK_WALK, 0, 0, 3'd4, 3'd1); expect_rej("R5 walk 128");
    send(0, 32'h4, MK_WALK, 0, 0, 3'd1, 3'd1); expect_rej("R5 walk 16");
    send(0, 32'h4, MK_WALK, 1, 1, 3'd2, 3'd1); expect_rej("R5 walk excl");
  endtask

  task automatic t_lock();
    send(0, 32'h300, MK_NC, 1, 1, 3'd2, 3'd1);
    chk(arvalid && arlock, "R6 nc shared excl", DW'(arlock), 1);
    serve_read(1, -1, 2'd0, 2'd1, 2'd1, "R6 exok");
    send(0, 32'h300, MK_DEV, 0, 0, 3'd2, 3'd1);
    chk(arvalid && !arlock, "R6 dev plain", DW'(arlock), 0);
    serve_read(1, -1, 2'd0, 2'd0, 2'd0, "R6 plain");
    send(1, 32'h403, MK_DEV, 0, 1, 3'd0, 3'd1);
    chk(awvalid && awlock && awsize == 3'd0, "R6 dev excl w", DW'(awlock), 1);
    wd_d[0] = 128'h5A; wd_b[0] = 16'h0001;
    ex_d[0] = 128'h5A << 24; ex_s[0] = 16'h0008;
    serve_write(1, 2'd1, "R6 dev w");
    send(1, 32'h500, MK_WT, 1, 1, 3'd4, 3'd1);
    chk(awvalid && awlock, "R6 wt shared excl", DW'(awlock), 1);
    wd_d[0] = {4{32'hFACEB00C}}; wd_b[0] = 16'hFFFF;
    ex_d[0] = {4{32'hFACEB00C}}; ex_s[0] = 16'hFFFF;
    serve_write(1, 2'd1, "R6 wt w");
  endtask

  task automatic t_write_single();
    send(1, 32'h105, MK_DEV, 0, 0, 3'd0, 3'd1);
    chk(awvalid && awaddr == 32'h105 && awlen == 8'd0 && awsize == 3'd0 && awburst == 2'b01,
        "R3 aw single", DW'({awlen, awsize, awburst}), DW'({8'd0, 3'd0, 2'b01}));
    wd_d[0] = 128'hAB; wd_b[0] = 16'hFFFF; ex_d[0] = 128'hAB << 40; ex_s[0] = 16'h0020;
    serve_write(1, 2'd0, "R7 byte5");
    send(1, 32'h48, MK_NC, 0, 0, 3'd2, 3'd1);
    wd_d[0] = 128'h11223344; wd_b[0] = 16'h0005; ex_d[0] = 128'h11223344 << 64; ex_s[0] = 16'h0500;
    serve_write(1, 2'd0, "R7 word8");
    send(1, 32'h8, MK_NC, 0, 0, 3'd3, 3'd1);
    wd_d[0] = 128'h77; wd_b[0] = 16'h0000; ex_d[0] = 128'h77 << 64; ex_s[0] = 16'h0000;
    serve_write(1, 2'd0, "R7 no strobes");
  endtask

  task automatic t_write_burst();
    send(1, 32'h40, MK_NC, 0, 0, 3'd4, 3'd4);
    chk(awvalid && awlen == 8'd3 && awsize == 3'd4 && awburst == 2'b01, "R3 aw burst",
        DW'({awlen, awsize}), DW'({8'd3, 3'd4}));
    wd_b[0] = 16'hFFFF; wd_b[1] = 16'h0000; wd_b[2] = 16'h00F0; wd_b[3] = 16'h8001;
    for (int i = 0; i < 4; i++) begin
      wd_d[i] = {4{32'hD0D00000 + 32'(i)}}; ex_d[i] = wd_d[i]; ex_s[i] = wd_b[i];
    end
    serve_write(4, 2'd0, "R8 burst4");
    send(1, 32'h1020, MK_DEV, 0, 0, 3'd4, 3'd2);
    chk(awvalid && awlen == 8'd1, "R3 aw len2", DW'(awlen), 1);
    for (int i = 0; i < 2; i++) begin
      wd_d[i] = {4{32'hE0E00000 + 32'(i)}}; wd_b[i] = 16'h0F0F; ex_d[i] = wd_d[i]; ex_s[i] = wd_b[i];
    end
    serve_write(2, 2'd2, "R10 slverr");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_reject_shapes();
    t_line_cross();
    t_read_burst();
    t_narrow_read();
    t_walk();
    t_lock();
    t_write_single();
    t_write_burst();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    #4000000;
    if (!done) begin
      done = 1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule